// File: doc/BRIEF.md
# 8-bit Arithmetic Logic Unit with Condition Flags

This block is the purely combinational datapath core of a small RISC processor's execute stage. It takes an operation code, two operands and the current carry and zero flags. In the same cycle it returns a result together with six condition flags: half-carry, sign, overflow, negative, zero and carry. With them comes a mask that tells the status register which of those flags the operation is allowed to update.

The operations are addition and subtraction, each with and without the incoming carry, the three bitwise logic operations, bitwise inversion, negation, increment, decrement, five single-bit shift and rotate forms, and a nibble exchange. Each operation has its own flag-update rule. Flag bits that the mask does not select are driven to zero. The status register is expected to merge the new flags under the mask.

The carry-chained subtract can only keep or clear the zero flag, so a multi-byte comparison built from a chain of subtracts reports zero only when every byte was zero.

Top module: `alu8_core`

## Requirements
- R1: Flag and mask bit positions are 0 C, 1 Z, 2 N, 3 V, 4 S, 5 H. Op 0 (add) returns a+b and ignores c_in_i. Op 1 (add with carry) returns a+b+c_in_i. Both mask all six flags. C is the carry out of bit 7, H is the carry out of bit 3, V is signed overflow, N is bit 7 of the result, and Z is set when the result is zero.
- R2: Op 2 (subtract) returns a-b, with all six flags masked. C is set on a borrow out of bit 7, H on a borrow out of bit 3, and V on signed overflow.
- R3: Op 3 (subtract with carry) returns a-b-c_in_i, with all six flags masked and C, H and V as in R2. Z is the AND of z_in_i with "result is zero", so it is never newly set.
- R4: Ops 4, 5 and 6 return a AND b, a OR b and a XOR b. They mask Z, N, V and S only, and V is always 0.
- R5: Op 7 returns the bitwise inverse of a. It masks Z, C, N, V and S, with C always 1 and V always 0.
- R6: Op 8 returns 0-a and masks all six flags. C, H and V are computed as for a subtraction with a zero minuend.
- R7: Op 9 returns a+1 and op 10 returns a-1. Both mask only Z, N, V and S, never C. V is set when the result is 0x80 (op 9) or 0x7F (op 10).
- R8: Op 11 shifts a left with 0 into bit 0 and bit 7 into C. Op 12 shifts a right with 0 into bit 7 and bit 0 into C.
- R9: Op 13 rotates left through carry, putting c_in_i into bit 0 and bit 7 into C. Op 14 rotates right through carry, putting c_in_i into bit 7 and bit 0 into C. Op 15 shifts right keeping bit 7, with bit 0 into C.
- R10: Ops 11 to 15 mask Z, C, N, V and S, and V equals N XOR C of the outcome.
- R11: Op 16 exchanges the high and low nibbles of a and masks no flag.
- R12: Whenever S is masked it equals N XOR V, and every flag bit outside the mask is 0.
- R13: Op codes 17 to 31 return a zero result with an empty mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 5 | Operation code |
| a_i | input | W (8) | First operand, and the only operand of single-operand ops |
| b_i | input | W (8) | Second operand |
| c_in_i | input | 1 | Current carry flag |
| z_in_i | input | 1 | Current zero flag |
| result_o | output | W (8) | Operation result |
| flags_o | output | 6 | New flag values {H,S,V,N,Z,C} |
| fmask_o | output | 6 | Flags updated by this op, same bit order |

## Verification
The checks assume the inputs are settled, known values. They also assume that c_in_i and z_in_i may take any value for any op, so the rules tying carry-in to add-with-carry and zero-in to subtract-with-carry are checked across all combinations. The stimulus changes inputs only on the falling clock edge and samples a quarter period later. A hand-computed vector table covers every op code, including the overflow boundaries 0x7F/0x80 and the zero-keeping cases. A grid sweep over operand pairs and both carry values then compares the four arithmetic ops against an integer model.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int FLAG_W = 6;
  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int FL_S = 4;
  localparam int FL_H = 5;

  localparam logic [FLAG_W-1:0] MK_ALL   = 6'b111111;
  localparam logic [FLAG_W-1:0] MK_ZNVS  = 6'b011110;
  localparam logic [FLAG_W-1:0] MK_ZCNVS = 6'b011111;
  localparam logic [FLAG_W-1:0] MK_NONE  = 6'b000000;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,  OP_ADC  = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
    OP_AND  = 5'd4,  OP_OR   = 5'd5,  OP_XOR = 5'd6,  OP_COM = 5'd7,
    OP_NEG  = 5'd8,  OP_INC  = 5'd9,  OP_DEC = 5'd10, OP_LSL = 5'd11,
    OP_LSR  = 5'd12, OP_ROL  = 5'd13, OP_ROR = 5'd14, OP_ASR = 5'd15,
    OP_SWAP = 5'd16
  } op_e;

  typedef enum logic [2:0] {
    BS_AND, BS_OR, BS_XOR, BS_COM, BS_SWAP
  } bsel_e;

  typedef enum logic [2:0] {
    SH_LSL, SH_LSR, SH_ROL, SH_ROR, SH_ASR
  } ssel_e;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         carry_o,
  output logic         half_o,
  output logic         ovf_o
);
  localparam int HB = W / 2;

  logic [W-1:0] b_eff;
  logic         c_eff;
  logic         co_raw;
  logic         hc_raw;

  // subtraction runs as a + ~b + ~borrow; carries invert into borrows
  assign b_eff = sub_i ? ~b_i : b_i;
  assign c_eff = sub_i ? ~cin_i : cin_i;
  assign {co_raw, sum_o} = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
  assign hc_raw  = a_i[HB] ^ b_eff[HB] ^ sum_o[HB];
  assign carry_o = sub_i ? ~co_raw : co_raw;
  assign half_o  = sub_i ? ~hc_raw : hc_raw;
  assign ovf_o   = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  bsel_e        sel_i,
  output logic [W-1:0] res_o
);
  localparam int HB = W / 2;

  logic [W-1:0] swapped;

  for (genvar i = 0; i < HB; i++) begin : g_swap
    assign swapped[i]      = a_i[i+HB];
    assign swapped[i+HB]   = a_i[i];
  end

  always_comb begin
    res_o = '0;
    case (sel_i)
      BS_AND:  res_o = a_i & b_i;
      BS_OR:   res_o = a_i | b_i;
      BS_XOR:  res_o = a_i ^ b_i;
      BS_COM:  res_o = ~a_i;
      BS_SWAP: res_o = swapped;
      default: res_o = '0;
    endcase
  end
endmodule

// File: rtl/alu8_shifter.sv
module alu8_shifter
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic         cin_i,
  input  ssel_e        sel_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);
  always_comb begin
    res_o  = '0;
    cout_o = 1'b0;
    case (sel_i)
      SH_LSL: begin res_o = {a_i[W-2:0], 1'b0};     cout_o = a_i[W-1]; end
      SH_LSR: begin res_o = {1'b0, a_i[W-1:1]};     cout_o = a_i[0];   end
      SH_ROL: begin res_o = {a_i[W-2:0], cin_i};    cout_o = a_i[W-1]; end
      SH_ROR: begin res_o = {cin_i, a_i[W-1:1]};    cout_o = a_i[0];   end
      SH_ASR: begin res_o = {a_i[W-1], a_i[W-1:1]}; cout_o = a_i[0];   end
      default: begin res_o = '0; cout_o = 1'b0; end
    endcase
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [4:0]        op_i,
  input  logic [W-1:0]      a_i,
  input  logic [W-1:0]      b_i,
  input  logic              c_in_i,
  input  logic              z_in_i,
  output logic [W-1:0]      result_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic [FLAG_W-1:0] fmask_o
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  logic [W-1:0] as_a, as_b, as_res, bo_res, sh_res;
  logic         as_cin, as_sub, as_c, as_h, as_v, sh_c;
  bsel_e        bsel;
  ssel_e        ssel;
  logic [W-1:0] res;
  logic         c_f, v_f, h_f, n_f, z_f, s_f, z_chain;
  logic [FLAG_W-1:0] mask;

  // operand and unit selection
  always_comb begin
    as_a   = a_i;
    as_b   = b_i;
    as_cin = 1'b0;
    as_sub = 1'b0;
    bsel   = BS_AND;
    ssel   = SH_LSL;
    case (op_i)
      OP_ADC:  as_cin = c_in_i;
      OP_SUB:  as_sub = 1'b1;
      OP_SBC:  begin as_sub = 1'b1; as_cin = c_in_i; end
      OP_NEG:  begin as_a = '0; as_b = a_i; as_sub = 1'b1; end
      OP_INC:  as_b = ONE;
      OP_DEC:  begin as_b = ONE; as_sub = 1'b1; end
      OP_OR:   bsel = BS_OR;
      OP_XOR:  bsel = BS_XOR;
      OP_COM:  bsel = BS_COM;
      OP_SWAP: bsel = BS_SWAP;
      OP_LSR:  ssel = SH_LSR;
      OP_ROL:  ssel = SH_ROL;
      OP_ROR:  ssel = SH_ROR;
      OP_ASR:  ssel = SH_ASR;
      default: ;
    endcase
  end

  alu8_addsub #(.W(W)) u_addsub (
    .a_i(as_a), .b_i(as_b), .cin_i(as_cin), .sub_i(as_sub),
    .sum_o(as_res), .carry_o(as_c), .half_o(as_h), .ovf_o(as_v)
  );

  alu8_bitops #(.W(W)) u_bitops (
    .a_i(a_i), .b_i(b_i), .sel_i(bsel), .res_o(bo_res)
  );

  alu8_shifter #(.W(W)) u_shifter (
    .a_i(a_i), .cin_i(c_in_i), .sel_i(ssel), .res_o(sh_res), .cout_o(sh_c)
  );

  // result and flag selection
  always_comb begin
    res     = '0;
    c_f     = 1'b0;
    v_f     = 1'b0;
    h_f     = 1'b0;
    mask    = MK_NONE;
    z_chain = 1'b0;
    case (op_i)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_NEG: begin
        res  = as_res;
        c_f  = as_c;
        v_f  = as_v;
        h_f  = as_h;
        mask = MK_ALL;
        z_chain = (op_i == OP_SBC);
      end
      OP_INC, OP_DEC: begin
        res  = as_res;
        v_f  = as_v;
        mask = MK_ZNVS;
      end
      OP_AND, OP_OR, OP_XOR: begin
        res  = bo_res;
        mask = MK_ZNVS;
      end
      OP_COM: begin
        res  = bo_res;
        c_f  = 1'b1;
        mask = MK_ZCNVS;
      end
      OP_SWAP: res = bo_res;
      OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
        res  = sh_res;
        c_f  = sh_c;
        v_f  = sh_res[W-1] ^ sh_c;
        mask = MK_ZCNVS;
      end
      default: ;
    endcase
  end

  assign n_f = res[W-1];
  assign z_f = z_chain ? (z_in_i && (res == '0)) : (res == '0);
  assign s_f = n_f ^ v_f;

  assign result_o = res;
  assign fmask_o  = mask;
  assign flags_o  = {h_f, s_f, v_f, n_f, z_f, c_f} & mask;
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input logic [4:0]        op_i,
  input logic [W-1:0]      a_i,
  input logic              z_in_i,
  input logic [W-1:0]      result_o,
  input logic [FLAG_W-1:0] flags_o,
  input logic [FLAG_W-1:0] fmask_o
);
  localparam int HB = W / 2;

  logic known;
  logic is_shift, is_logic;

  assign known    = !$isunknown({op_i, a_i, z_in_i, result_o, flags_o, fmask_o});
  assign is_shift = (op_i >= OP_LSL) && (op_i <= OP_ASR);
  assign is_logic = (op_i >= OP_AND) && (op_i <= OP_XOR);

  always_comb begin
    if (known) begin
      AST_UNMASKED_ZERO: assert ((flags_o & ~fmask_o) == '0)
        else $error("flag outside mask"); // R12
      AST_ZERO_MATCH: assert (!(fmask_o[FL_Z] && op_i != OP_SBC) ||
                              (flags_o[FL_Z] == (result_o == '0)))
        else $error("zero flag mismatch"); // R1
      AST_SBC_Z_NOSET: assert (!(op_i == OP_SBC && !z_in_i) || !flags_o[FL_Z])
        else $error("chained subtract set Z"); // R3
      AST_LOGIC_NO_V: assert (!is_logic || !flags_o[FL_V])
        else $error("logic op set V"); // R4
      AST_COM_CARRY: assert (op_i != OP_COM || (flags_o[FL_C] && result_o == ~a_i))
        else $error("inversion wrong"); // R5
      AST_INCDEC_KEEP_C: assert (!(op_i == OP_INC || op_i == OP_DEC) || !fmask_o[FL_C])
        else $error("inc/dec touches C"); // R7
      AST_SHIFT_V: assert (!is_shift ||
                           flags_o[FL_V] == (flags_o[FL_N] ^ flags_o[FL_C]))
        else $error("shift V rule"); // R10
      AST_SWAP_QUIET: assert (op_i != OP_SWAP ||
                              (fmask_o == '0 && result_o == {a_i[HB-1:0], a_i[W-1:HB]}))
        else $error("swap wrong"); // R11
      AST_BAD_OP: assert (op_i <= OP_SWAP || (result_o == '0 && fmask_o == '0))
        else $error("undefined op not quiet"); // R13
    end
  end
endmodule

bind alu8_core alu8_core_chk #(.W(W)) u_chk (
  .op_i(op_i), .a_i(a_i), .z_in_i(z_in_i),
  .result_o(result_o), .flags_o(flags_o), .fmask_o(fmask_o)
);

// File: tb/alu8_core_bench.sv
module alu8_core_bench;
  import alu8_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 32;
  localparam int WATCHDOG = 50000;

  logic       clk;
  logic       rst_n;
  logic [4:0] op;
  logic [7:0] a, b;
  logic       cin, zin;
  logic [7:0] res;
  logic [5:0] fl, mk;
  int n_chk, n_bad, cyc;

  alu8_core #(.W(8)) u_alu8_core (
    .op_i(op), .a_i(a), .b_i(b), .c_in_i(cin), .z_in_i(zin),
    .result_o(res), .flags_o(fl), .fmask_o(mk)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  initial cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  // {op, a, b, cin, zin, result, flags HSVNZC, mask HSVNZC}
  localparam logic [42:0] VEC [NVEC] = '{
    {OP_ADD, 8'h0F, 8'h01, 1'b0, 1'b0, 8'h10, 6'b100000, 6'b111111},
    {OP_ADD, 8'h7F, 8'h01, 1'b0, 1'b0, 8'h80, 6'b101100, 6'b111111},
    {OP_ADD, 8'hFF, 8'h01, 1'b0, 1'b0, 8'h00, 6'b100011, 6'b111111},
    {OP_ADD, 8'h01, 8'h01, 1'b1, 1'b0, 8'h02, 6'b000000, 6'b111111},
    {OP_ADC, 8'h10, 8'h20, 1'b1, 1'b0, 8'h31, 6'b000000, 6'b111111},
    {OP_ADC, 8'h08, 8'h07, 1'b1, 1'b0, 8'h10, 6'b100000, 6'b111111},
    {OP_SUB, 8'h10, 8'h01, 1'b0, 1'b0, 8'h0F, 6'b100000, 6'b111111},
    {OP_SUB, 8'h00, 8'h01, 1'b0, 1'b0, 8'hFF, 6'b110101, 6'b111111},
    {OP_SUB, 8'h80, 8'h01, 1'b1, 1'b0, 8'h7F, 6'b111000, 6'b111111},
    {OP_SBC, 8'h05, 8'h05, 1'b0, 1'b1, 8'h00, 6'b000010, 6'b111111},
    {OP_SBC, 8'h05, 8'h05, 1'b0, 1'b0, 8'h00, 6'b000000, 6'b111111},
    {OP_SBC, 8'h05, 8'h04, 1'b1, 1'b1, 8'h00, 6'b000010, 6'b111111},
    {OP_SBC, 8'h06, 8'h04, 1'b1, 1'b1, 8'h01, 6'b000000, 6'b111111},
    {OP_AND, 8'hF0, 8'h0F, 1'b1, 1'b0, 8'h00, 6'b000010, 6'b011110},
    {OP_OR,  8'h80, 8'h01, 1'b0, 1'b0, 8'h81, 6'b010100, 6'b011110},
    {OP_XOR, 8'hFF, 8'hFF, 1'b0, 1'b0, 8'h00, 6'b000010, 6'b011110},
    {OP_COM, 8'h00, 8'h55, 1'b0, 1'b0, 8'hFF, 6'b010101, 6'b011111},
    {OP_NEG, 8'h80, 8'h00, 1'b0, 1'b0, 8'h80, 6'b001101, 6'b111111},
    {OP_NEG, 8'h01, 8'h00, 1'b0, 1'b0, 8'hFF, 6'b110101, 6'b111111},
    {OP_NEG, 8'h00, 8'h00, 1'b1, 1'b0, 8'h00, 6'b000010, 6'b111111},
    {OP_INC, 8'h7F, 8'h00, 1'b1, 1'b0, 8'h80, 6'b001100, 6'b011110},
    {OP_INC, 8'hFF, 8'h00, 1'b0, 1'b0, 8'h00, 6'b000010, 6'b011110},
    {OP_DEC, 8'h80, 8'h00, 1'b1, 1'b0, 8'h7F, 6'b011000, 6'b011110},
    {OP_DEC, 8'h01, 8'h00, 1'b0, 1'b0, 8'h00, 6'b000010, 6'b011110},
    {OP_LSL, 8'h81, 8'h00, 1'b1, 1'b0, 8'h02, 6'b011001, 6'b011111},
    {OP_LSR, 8'h01, 8'h00, 1'b1, 1'b0, 8'h00, 6'b011011, 6'b011111},
    {OP_ROL, 8'h80, 8'h00, 1'b1, 1'b0, 8'h01, 6'b011001, 6'b011111},
    {OP_ROR, 8'h02, 8'h00, 1'b1, 1'b0, 8'h81, 6'b001100, 6'b011111},
    {OP_ASR, 8'h81, 8'h00, 1'b0, 1'b0, 8'hC0, 6'b010101, 6'b011111},
    {OP_SWAP, 8'hA5, 8'h00, 1'b1, 1'b1, 8'h5A, 6'b000000, 6'b000000},
    {5'd17,  8'hFF, 8'hFF, 1'b1, 1'b1, 8'h00, 6'b000000, 6'b000000},
    {5'd31,  8'h80, 8'h7F, 1'b1, 1'b0, 8'h00, 6'b000000, 6'b000000}
  };

  function automatic string req_of(logic [4:0] o, bit for_flags);
    case (o)
      OP_ADD, OP_ADC:         return "R1";
      OP_SUB:                 return "R2";
      OP_SBC:                 return "R3";
      OP_AND, OP_OR, OP_XOR:  return "R4";
      OP_COM:                 return "R5";
      OP_NEG:                 return "R6";
      OP_INC, OP_DEC:         return "R7";
      OP_LSL, OP_LSR:         return for_flags ? "R10" : "R8";
      OP_ROL, OP_ROR, OP_ASR: return for_flags ? "R10" : "R9";
      OP_SWAP:                return "R11";
      default:                return "R13";
    endcase
  endfunction

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s op=%0d a=%h b=%h cin=%b zin=%b: got %h expected %h",
               tag, op, a, b, cin, zin, got, exp);
    end
  endtask

  task automatic drive(logic [4:0] o, logic [7:0] x, logic [7:0] y, logic c, logic z);
    @(negedge clk);
    op = o; a = x; b = y; cin = c; zin = z;
    #(CLK_PERIOD/4);
  endtask

  // integer model of the four arithmetic ops
  task automatic arith_model(logic [4:0] o, output logic [7:0] r, output logic [5:0] f);
    int ci, full, lo, sv;
    bit is_sub, cf, hf, vf, nf, zf;
    ci = (o == OP_ADC || o == OP_SBC) ? int'(cin) : 0;
    is_sub = (o == OP_SUB || o == OP_SBC);
    if (is_sub) begin
      full = int'(a) - int'(b) - ci;
      lo   = int'(a[3:0]) - int'(b[3:0]) - ci;
      sv   = int'($signed(a)) - int'($signed(b)) - ci;
      cf = full < 0; hf = lo < 0;
    end else begin
      full = int'(a) + int'(b) + ci;
      lo   = int'(a[3:0]) + int'(b[3:0]) + ci;
      sv   = int'($signed(a)) + int'($signed(b)) + ci;
      cf = full > 255; hf = lo > 15;
    end
    vf = (sv > 127) || (sv < -128);
    r  = full[7:0];
    nf = r[7];
    zf = (r == 8'h00) && (o != OP_SBC || zin);
    f  = {hf, nf ^ vf, vf, nf, zf, cf};
  endtask

  initial begin
    n_chk = 0;
    n_bad = 0;
    rst_n = 1'b0;
    op = OP_ADD; a = 8'h00; b = 8'h00; cin = 1'b0; zin = 1'b0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // initial state: zero operands on op 0 give zero with Z set (R1)
    drive(OP_ADD, 8'h00, 8'h00, 1'b0, 1'b0);
    check("R1", {8'h00, res}, {8'h00, 8'h00});
    check("R1", {10'd0, fl}, {10'd0, 6'b000010});

    // vector table
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][42:38], VEC[i][37:30], VEC[i][29:22], VEC[i][21], VEC[i][20]);
      check(req_of(op, 1'b0), {8'h00, res}, {8'h00, VEC[i][19:12]});
      check(req_of(op, 1'b1), {10'd0, fl}, {10'd0, VEC[i][11:6]});
      check("R12", {10'd0, mk}, {10'd0, VEC[i][5:0]});
    end

    // carry-in must not reach rotate-free shifts (R8)
    drive(OP_LSR, 8'h80, 8'h00, 1'b1, 1'b0);
    check("R8", {8'h00, res}, {8'h00, 8'h40});

    // sign rule across every op with N/V masked (R12)
    for (int o = 0; o <= 16; o++) begin
      drive(o[4:0], 8'hC3, 8'h5A, 1'b1, 1'b1);
      if (mk[4]) check("R12", {15'd0, fl[4]}, {15'd0, fl[2] ^ fl[3]});
    end

    // grid sweep of the arithmetic ops against the integer model (R1 R2 R3)
    for (int o = 0; o < 4; o++) begin
      for (int ia = 0; ia < 16; ia++) begin
        for (int ib = 0; ib < 16; ib++) begin
          for (int c = 0; c < 2; c++) begin
            logic [7:0] er;
            logic [5:0] ef;
            drive(o[4:0], 8'(ia * 17), 8'(ib * 15 + 3), c[0], ib[0]);
            arith_model(op, er, ef);
            check(o < 2 ? "R1" : (o == 2 ? "R2" : "R3"), {res, 2'b00, fl}, {er, 2'b00, ef});
          end
        end
      end
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    wait (cyc >= WATCHDOG);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run exceeded %0d cycles", WATCHDOG);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule